// File: doc/BRIEF.md
# Joystick Polling Transaction Sequencer

This block sits above a small 8-bit SPI master and runs one complete read exchange with a two-axis joystick peripheral each time it is asked. On a request it pulls slave select low and waits a setup interval. Before each of five byte exchanges it waits a shorter gap. It then releases slave select and unpacks the five received bytes into a 10-bit X position, a 10-bit Y position and three button flags. The new values appear together with a single-cycle valid pulse. Requests that arrive while an exchange is running are dropped.

A free-running period timer advances a 2-bit LED code that wraps from 3 back to 0. The code is latched when a request is accepted and goes out as the first transmitted byte, with the top bit forced high. All intervals are cycle counts derived from the clock frequency parameter, the requested microsecond values and the requested serial clock rate.

The controller has five states. ST_IDLE leaves for ST_SETUP on a request. ST_SETUP leaves for ST_GAP when the setup count expires. ST_GAP leaves for ST_XFER when the gap count expires, and that transition starts a byte. ST_XFER waits for the byte to finish. It goes back to ST_GAP if bytes remain, or to ST_FINISH after the fifth byte. ST_FINISH always returns to ST_IDLE.

Top module: `joy_poll_seq`

## Requirements
- R1: After reset, js_ss_n is high, js_sck is low, busy and sample_valid are low, and x_pos, y_pos, buttons and led_code are all zero.
- R2: A poll_req high at a clock edge while idle drives js_ss_n low after that edge. The first rising js_sck edge comes at least SETUP_US plus GAP_US microseconds' worth of cycles after js_ss_n falls.
- R3: Between the last falling js_sck of one byte and the first rising js_sck of the next, at least GAP_US microseconds' worth of cycles pass.
- R4: Each exchange has exactly five bytes of eight js_sck pulses each. js_ss_n returns high one clock after the final falling js_sck, and js_sck never rises while js_ss_n is high.
- R5: The first byte sent on js_mosi is 0x80 OR led_code, where led_code is the value held just before the accepting edge (bit 0 is LED1, bit 1 is LED2). The other four bytes are 0x00.
- R6: Serial timing is SPI mode 1, MSB first. js_sck idles low. js_mosi changes on rising js_sck and js_miso is sampled on falling js_sck. Each js_sck level lasts ceil(CLK_HZ / (2*SCK_HZ)) cycles.
- R7: x_pos is {byte2[1:0], byte1} and y_pos is {byte4[1:0], byte3}, counting received bytes from 1. The upper six bits of bytes 2 and 4 are ignored.
- R8: buttons takes bits 2:0 of received byte 5: bit 0 is the stick switch, bit 1 is button 1 and bit 2 is button 2. Bits 7:3 are ignored.
- R9: sample_valid is a one-cycle pulse one clock after js_ss_n returns high. x_pos, y_pos and buttons change only in that cycle.
- R10: A poll_req while busy is high has no effect: no new exchange follows and no extra sample_valid appears.
- R11: led_code advances by one, wrapping 3 to 0, at every LED_PERIOD_US microseconds' worth of clock edges counted from reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_req | input | 1 | Start one read exchange |
| busy | output | 1 | Exchange in progress |
| js_ss_n | output | 1 | Slave select, active low |
| js_sck | output | 1 | Serial clock |
| js_mosi | output | 1 | Serial data to peripheral |
| js_miso | input | 1 | Serial data from peripheral |
| x_pos | output | 10 | X position |
| y_pos | output | 10 | Y position |
| buttons | output | 3 | Button flags |
| sample_valid | output | 1 | One-cycle pulse marking new outputs |
| led_code | output | 2 | LED code sent in the next command byte |

## Verification
The bench counts clock edges and places each result in its cycle. led_code is compared every cycle against the edge count divided by the period. sample_valid must appear exactly one cycle after js_ss_n rises, and js_ss_n must rise exactly one cycle after the last falling js_sck. The setup interval, the gaps and the serial half periods are measured in edges between slave-select and serial-clock transitions, because they are minimums or exact counts. Outputs are sampled on the falling clock edge, and x_pos, y_pos and buttons are held to their previous values in every cycle without sample_valid.

// File: rtl/joy_poll_pkg.sv
package joy_poll_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 5;
    localparam int POS_W       = 10;
    localparam int BTN_W       = 3;
    localparam int LED_W       = 2;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_GAP,
        ST_XFER,
        ST_FINISH
    } seq_state_t;

    // Command byte: top bit set, LED code in the low bits
    function automatic logic [BYTE_W-1:0] led_cmd(input logic [LED_W-1:0] led);
        led_cmd = {1'b1, {(BYTE_W-LED_W-1){1'b0}}, led};
    endfunction
endpackage

// File: rtl/joy_gap_timer.sv
module joy_gap_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/joy_led_ticker.sv
module joy_led_ticker #(
    parameter int PERIOD_CYC = 1000,
    parameter int LED_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    output logic [LED_W-1:0] led
);
    localparam int CW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            led   <= '0;
        end else if (cnt_q == CW'(PERIOD_CYC - 1)) begin
            cnt_q <= '0;
            led   <= led + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/joy_spi_byte.sv
module joy_spi_byte #(
    parameter int HALF_CYC = 4,
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BW = $clog2(BYTE_W);

    logic              active_q;
    logic [HW-1:0]     half_q;
    logic [BW-1:0]     bit_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            half_q   <= '0;
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            sck      <= 1'b0;
            mosi     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active_q) begin
                active_q <= 1'b1;
                half_q   <= HW'(HALF_CYC - 1);
                bit_q    <= '0;
                tx_q     <= tx_byte;
                sck      <= 1'b0;
            end else if (active_q) begin
                if (half_q != '0) begin
                    half_q <= half_q - 1'b1;
                end else begin
                    half_q <= HW'(HALF_CYC - 1);
                    if (!sck) begin
                        // leading edge: present next bit
                        sck  <= 1'b1;
                        mosi <= tx_q[BYTE_W-1];
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                    end else begin
                        // trailing edge: capture input bit
                        sck   <= 1'b0;
                        rx_q  <= {rx_q[BYTE_W-2:0], miso};
                        bit_q <= bit_q + 1'b1;
                        if (bit_q == BW'(BYTE_W - 1)) begin
                            active_q <= 1'b0;
                            done     <= 1'b1;
                            mosi     <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign rx_byte = rx_q;
endmodule

// File: rtl/joy_poll_seq.sv
module joy_poll_seq
    import joy_poll_pkg::*;
#(
    parameter int CLK_HZ        = 125_000_000,
    parameter int SCK_HZ        = 100_000,
    parameter int SETUP_US      = 15,
    parameter int GAP_US        = 10,
    parameter int LED_PERIOD_US = 205_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             poll_req,
    output logic             busy,
    output logic             js_ss_n,
    output logic             js_sck,
    output logic             js_mosi,
    input  logic             js_miso,
    output logic [POS_W-1:0] x_pos,
    output logic [POS_W-1:0] y_pos,
    output logic [BTN_W-1:0] buttons,
    output logic             sample_valid,
    output logic [LED_W-1:0] led_code
);
    localparam int CYC_PER_US     = CLK_HZ / 1_000_000;
    localparam int SETUP_CYC      = CYC_PER_US * SETUP_US;
    localparam int GAP_CYC        = CYC_PER_US * GAP_US;
    localparam int LED_PERIOD_CYC = CYC_PER_US * LED_PERIOD_US;
    localparam int HALF_CYC       = (CLK_HZ + 2 * SCK_HZ - 1) / (2 * SCK_HZ);
    localparam int TMR_MAX        = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
    localparam int TMR_W          = $clog2(TMR_MAX + 1);
    localparam int HI_BITS        = POS_W - BYTE_W;

    seq_state_t state_q, state_d;

    logic                               tmr_load;
    logic [TMR_W-1:0]                   tmr_val;
    logic                               tmr_expired;
    logic                               spi_start;
    logic                               spi_done;
    logic [BYTE_W-1:0]                  spi_rx;
    logic [BYTE_W-1:0]                  spi_tx;
    logic [IDX_W-1:0]                   idx_q;
    logic [BYTE_W-1:0]                  cmd_q;
    logic [FRAME_BYTES-1:0][BYTE_W-1:0] rx_q;
    logic                               last_byte;

    joy_gap_timer #(.W(TMR_W)) gap_tmr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    joy_led_ticker #(.PERIOD_CYC(LED_PERIOD_CYC), .LED_W(LED_W)) led_tick_i (
        .clk (clk),
        .rst (rst),
        .led (led_code)
    );

    joy_spi_byte #(.HALF_CYC(HALF_CYC), .BYTE_W(BYTE_W)) shifter_i (
        .clk     (clk),
        .rst     (rst),
        .start   (spi_start),
        .tx_byte (spi_tx),
        .miso    (js_miso),
        .sck     (js_sck),
        .mosi    (js_mosi),
        .done    (spi_done),
        .rx_byte (spi_rx)
    );

    assign last_byte = (idx_q == IDX_W'(FRAME_BYTES - 1));
    assign spi_tx    = (idx_q == '0) ? cmd_q : '0;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control strobes
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        spi_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (poll_req) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(GAP_CYC - 1);
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    state_d   = ST_XFER;
                    spi_start = 1'b1;
                end
            end
            ST_XFER: begin
                if (spi_done) begin
                    if (last_byte) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d  = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(GAP_CYC - 1);
                    end
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign js_ss_n = (state_q == ST_IDLE) || (state_q == ST_FINISH);
    assign busy    = (state_q != ST_IDLE);

    // Datapath and registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q        <= '0;
            cmd_q        <= '0;
            rx_q         <= '0;
            x_pos        <= '0;
            y_pos        <= '0;
            buttons      <= '0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            if (state_q == ST_IDLE && poll_req) begin
                cmd_q <= led_cmd(led_code);
                idx_q <= '0;
            end
            if (state_q == ST_XFER && spi_done) begin
                rx_q[idx_q] <= spi_rx;
                if (!last_byte) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (state_q == ST_FINISH) begin
                x_pos        <= {rx_q[1][HI_BITS-1:0], rx_q[0]};
                y_pos        <= {rx_q[3][HI_BITS-1:0], rx_q[2]};
                buttons      <= rx_q[4][BTN_W-1:0];
                sample_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/joy_poll_seq_chk.sv
module joy_poll_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       poll_req,
    input logic       busy,
    input logic       js_ss_n,
    input logic       js_sck,
    input logic [9:0] x_pos,
    input logic [9:0] y_pos,
    input logic [2:0] buttons,
    input logic       sample_valid,
    input logic [1:0] led_code
);
    assert_select_on_request_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(js_ss_n) |-> ($past(poll_req) && !$past(busy)));

    assert_sck_only_selected_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(js_sck) |-> !js_ss_n);

    assert_sck_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
        js_ss_n |-> !js_sck);

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    assert_valid_after_release_R9: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (js_ss_n && $past(js_ss_n)));

    assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> ($stable(x_pos) && $stable(y_pos) && $stable(buttons)));

    assert_led_step_R11: assert property (@(posedge clk) disable iff (rst)
        (led_code != $past(led_code)) |-> (led_code == $past(led_code) + 2'd1));
endmodule

bind joy_poll_seq joy_poll_seq_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .poll_req     (poll_req),
    .busy         (busy),
    .js_ss_n      (js_ss_n),
    .js_sck       (js_sck),
    .x_pos        (x_pos),
    .y_pos        (y_pos),
    .buttons      (buttons),
    .sample_valid (sample_valid),
    .led_code     (led_code)
);

// File: tb/joy_poll_seq_tb_top.sv
module joy_poll_seq_tb_top;
    localparam int CLK_HZ   = 125_000_000;
    localparam int SCK_HZ   = 5_000_000;
    localparam int SETUP_US = 15;
    localparam int GAP_US   = 10;
    localparam int LED_US   = 30;
    localparam int CPU      = CLK_HZ / 1_000_000;
    localparam int SETUP_C  = CPU * SETUP_US;
    localparam int GAP_C    = CPU * GAP_US;
    localparam int LED_P    = CPU * LED_US;
    localparam int HALF     = (CLK_HZ + 2 * SCK_HZ - 1) / (2 * SCK_HZ);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       poll_req = 1'b0;
    logic       busy, js_ss_n, js_sck, js_mosi;
    logic       js_miso = 1'b0;
    logic [9:0] x_pos, y_pos;
    logic [2:0] buttons;
    logic       sample_valid;
    logic [1:0] led_code;

    joy_poll_seq #(
        .CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ), .SETUP_US(SETUP_US),
        .GAP_US(GAP_US), .LED_PERIOD_US(LED_US)
    ) dut_i (
        .clk(clk), .rst(rst), .poll_req(poll_req), .busy(busy),
        .js_ss_n(js_ss_n), .js_sck(js_sck), .js_mosi(js_mosi), .js_miso(js_miso),
        .x_pos(x_pos), .y_pos(y_pos), .buttons(buttons),
        .sample_valid(sample_valid), .led_code(led_code)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int edges    = 0;
    int txn_cnt  = 0;
    int valid_cnt = 0;
    int ss_rise_cyc = 0;
    bit finished = 1'b0;

    logic [7:0] reply [5];
    logic [1:0] prev_led = 2'd0;
    logic [9:0] pend_x = '0, pend_y = '0, hold_x = '0, hold_y = '0;
    logic [2:0] pend_b = '0, hold_b = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst) edges++;
    end

    // Reference model compared every cycle
    always @(negedge clk) begin
        if (!rst) begin
            chk(led_code == 2'((edges / LED_P) % 4), "R11 led_code", led_code, (edges / LED_P) % 4);
            if (js_ss_n) chk(js_sck == 1'b0, "R6 sck idle low", js_sck, 0);
            if (sample_valid) begin
                valid_cnt++;
                chk(cyc == ss_rise_cyc + 1, "R9 valid timing", cyc, ss_rise_cyc + 1);
                chk(x_pos == pend_x, "R7 x_pos", x_pos, pend_x);
                chk(y_pos == pend_y, "R7 y_pos", y_pos, pend_y);
                chk(buttons == pend_b, "R8 buttons", buttons, pend_b);
                hold_x = pend_x; hold_y = pend_y; hold_b = pend_b;
            end else begin
                chk(x_pos == hold_x && y_pos == hold_y && buttons == hold_b,
                    "R9 hold", {x_pos, y_pos, buttons}, {hold_x, hold_y, hold_b});
            end
        end
        prev_led = led_code;
    end

    // Behavioural mode-1 peripheral
    initial begin
        forever begin
            int fall_cyc;
            int last_fall;
            logic [1:0] led_at_start;
            logic [7:0] got [5];
            @(negedge js_ss_n);
            fall_cyc = cyc;
            led_at_start = prev_led;
            last_fall = cyc;
            for (int b = 0; b < 5; b++) begin
                got[b] = 8'h00;
                for (int k = 0; k < 8; k++) begin
                    int rise_cyc;
                    @(posedge js_sck);
                    rise_cyc = cyc;
                    if (b == 0 && k == 0)
                        chk(rise_cyc - fall_cyc >= SETUP_C + GAP_C, "R2 setup delay",
                            rise_cyc - fall_cyc, SETUP_C + GAP_C);
                    else if (k == 0)
                        chk(rise_cyc - last_fall >= GAP_C, "R3 byte gap",
                            rise_cyc - last_fall, GAP_C);
                    else
                        chk(rise_cyc - last_fall == HALF, "R6 low half", rise_cyc - last_fall, HALF);
                    js_miso = reply[b][7-k];
                    @(negedge js_sck);
                    chk(cyc - rise_cyc == HALF, "R6 high half", cyc - rise_cyc, HALF);
                    got[b] = {got[b][6:0], js_mosi};
                    last_fall = cyc;
                end
            end
            @(posedge js_ss_n);
            ss_rise_cyc = cyc;
            chk(cyc == last_fall + 1, "R4 release after fifth byte", cyc, last_fall + 1);
            chk(got[0] == {6'b100000, led_at_start}, "R5 command byte", got[0], {6'b100000, led_at_start});
            for (int b = 1; b < 5; b++)
                chk(got[b] == 8'h00, "R5 filler byte", got[b], 0);
            txn_cnt++;
        end
    end

    task automatic run_txn(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                           input logic [7:0] b3, input logic [7:0] b4,
                           input int wait_before, input bit poke_busy);
        int t0;
        int v0;
        repeat (wait_before) @(negedge clk);
        reply[0] = b0; reply[1] = b1; reply[2] = b2; reply[3] = b3; reply[4] = b4;
        pend_x = {b1[1:0], b0};
        pend_y = {b3[1:0], b2};
        pend_b = b4[2:0];
        t0 = txn_cnt;
        v0 = valid_cnt;
        poll_req = 1'b1;
        @(negedge clk);
        poll_req = 1'b0;
        chk(js_ss_n == 1'b0 && busy == 1'b1, "R2 select on request", {js_ss_n, busy}, 2'b01);
        if (poke_busy) begin
            repeat (2000) @(negedge clk);
            chk(busy == 1'b1, "R10 still busy", busy, 1);
            poll_req = 1'b1;
            @(negedge clk);
            poll_req = 1'b0;
        end
        while (!sample_valid) @(negedge clk);
        repeat (300) @(negedge clk);
        chk(txn_cnt == t0 + 1, "R4 one exchange per request", txn_cnt, t0 + 1);
        chk(valid_cnt == v0 + 1, "R10 one valid per request", valid_cnt, v0 + 1);
        chk(js_ss_n == 1'b1 && busy == 1'b0, "R10 idle after exchange", {js_ss_n, busy}, 2'b10);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(js_ss_n == 1'b1, "R1 ss_n", js_ss_n, 1);
        chk(js_sck == 1'b0 && busy == 1'b0 && sample_valid == 1'b0, "R1 controls",
            {js_sck, busy, sample_valid}, 0);
        chk(x_pos == 0 && y_pos == 0 && buttons == 0 && led_code == 0, "R1 outputs",
            {x_pos, y_pos, buttons, led_code}, 0);
        rst = 1'b0;
        run_txn(8'hF2, 8'h03, 8'h0D, 8'h02, 8'h05, 10, 1'b0);
        run_txn(8'h00, 8'hFC, 8'hFF, 8'hFF, 8'h07, 1200, 1'b1);
        run_txn(8'h55, 8'hAA, 8'h3C, 8'hC1, 8'hF8, 2500, 1'b0);
        run_txn(8'hFF, 8'hFF, 8'h00, 8'h00, 8'h02, 700, 1'b0);
        run_txn(8'h80, 8'h01, 8'h7F, 8'h02, 8'h01, 3100, 1'b1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end
endmodule